// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns an accepted column command into one beat per clock of an SDRAM read or write burst. For each beat it gives the column address, a valid strobe, a read/write flag and a last-beat marker. The burst starts at the column presented with the command. It runs for the number of beats selected by a 3-bit burst-length field, which is sampled together with the command.

Column commands may arrive on any cycle, including while a burst is still running. A command that arrives mid-burst drops every remaining beat of the old burst. The following cycle already carries the new start column, and a fresh burst of full length follows it. Within a burst the column advances in sequential order. It wraps inside the aligned block whose size is the burst length, so only the low-order column bits ever change.

Top module: `sdram_burst_addr_gen`

## Requirements
- R1: While rst_ni is low, beat_valid_o, beat_last_o, busy_o, beat_write_o and beat_col_o are all zero.
- R2: Burst-length codes 3'b000, 3'b001, 3'b010 and 3'b011 give 1, 2, 4 and 8 beats. beat_valid_o is high for exactly that many consecutive cycles, starting in the cycle after the command is sampled.
- R3: The first beat appears in the cycle after cmd_valid_i is sampled high, and its beat_col_o equals the cmd_col_i sampled with the command.
- R4: Each later beat adds one, modulo the burst length, to the low log2(burst length) bits of the previous column. All higher column bits keep the start column's value.
- R5: A command sampled while a burst is running cancels the remaining beats of that burst. The next cycle shows the new start column, followed by a full burst of the new length.
- R6: beat_last_o is high on the final beat of a burst and on no other cycle.
- R7: busy_o is high on every beat from the first to the last, stays high without a gap across an interrupting command, and is low when no beat is produced.
- R8: beat_write_o on every beat equals the cmd_write_i value (1 = write, 0 = read) sampled with the command that started the burst. An interrupting command replaces it.
- R9: Burst-length codes 3'b100 to 3'b111 produce a single beat.
- R10: A change of burst_len_i while a burst is running has no effect on that burst's length or columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_len_i | input | 3 | Burst-length code, sampled with a command |
| cmd_valid_i | input | 1 | Column command present this cycle |
| cmd_write_i | input | 1 | 1 = write command, 0 = read command |
| cmd_col_i | input | COL_W | Start column of the command |
| beat_valid_o | output | 1 | A burst beat is produced this cycle |
| beat_col_o | output | COL_W | Column address of the current beat |
| beat_write_o | output | 1 | Direction of the current beat |
| beat_last_o | output | 1 | Current beat is the final one of its burst |
| busy_o | output | 1 | A burst is in progress |

## Verification
The bench builds the block with its defaults: a 9-bit column and a maximum burst of 8 beats. With an 8-beat burst, start columns at every offset inside an aligned block bring the wrap from the top of the block to its base into view, while the column bits above bit 2 must stay fixed. The 3-bit length field lets the stimulus reach all four legal lengths and all four reserved codes. A long random phase issues commands on about a quarter of the cycles and randomizes the length code on each one. This produces interrupts at every beat position of every length, back-to-back commands, and mid-burst length changes. The bench compares all of these against its behavioural reference.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int unsigned BL_CODE_W = 3;

  typedef enum logic [BL_CODE_W-1:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011
  } bl_code_e;

  // Offset mask (burst length - 1) for a code; codes beyond the supported range give a single beat.
  function automatic logic [7:0] bl_mask(input logic [BL_CODE_W-1:0] code, input int unsigned cnt_w);
    logic [7:0] m;
    m = '0;
    if (int'(code) <= int'(cnt_w)) begin
      for (int i = 0; i < 8; i++) begin
        if (i < int'(code)) m[i] = 1'b1;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import sdram_burst_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic [BL_CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]     mask_o
);
  logic [7:0] full_mask;

  always_comb begin
    full_mask = bl_mask(code_i, CNT_W);
    mask_o    = full_mask[CNT_W-1:0];
  end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] beats_m1_i,
  output logic             active_o,
  output logic             last_o
);
  logic             active_q;
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      remain_q <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      remain_q <= beats_m1_i;
    end else if (active_q) begin
      if (remain_q == '0) active_q <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign last_o   = active_q && (remain_q == '0);
endmodule

// File: rtl/burst_col_stepper.sv
module burst_col_stepper #(
  parameter int unsigned COL_W = 9,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             write_i,
  input  logic [CNT_W-1:0] mask_i,
  output logic [COL_W-1:0] col_o,
  output logic             write_o
);
  logic [COL_W-1:0] col_q;
  logic [CNT_W-1:0] mask_q;
  logic             write_q;
  logic [CNT_W-1:0] low_inc;
  logic [CNT_W-1:0] low_nxt;

  // Wrap inside the aligned block: bits outside the mask are frozen.
  always_comb begin
    low_inc = col_q[CNT_W-1:0] + 1'b1;
    low_nxt = (col_q[CNT_W-1:0] & ~mask_q) | (low_inc & mask_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q   <= '0;
      mask_q  <= '0;
      write_q <= 1'b0;
    end else if (load_i) begin
      col_q   <= col_i;
      mask_q  <= mask_i;
      write_q <= write_i;
    end else if (step_i) begin
      col_q[CNT_W-1:0] <= low_nxt;
    end
  end

  assign col_o   = col_q;
  assign write_o = write_q;
endmodule

// File: rtl/sdram_burst_addr_gen.sv
module sdram_burst_addr_gen
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W  = 9,
  parameter int unsigned MAX_BL = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BL_CODE_W-1:0] burst_len_i,
  input  logic                 cmd_valid_i,
  input  logic                 cmd_write_i,
  input  logic [COL_W-1:0]     cmd_col_i,
  output logic                 beat_valid_o,
  output logic [COL_W-1:0]     beat_col_o,
  output logic                 beat_write_o,
  output logic                 beat_last_o,
  output logic                 busy_o
);
  localparam int unsigned CNT_W = $clog2(MAX_BL);

  logic [CNT_W-1:0] mask;
  logic             active;
  logic             last;
  logic [COL_W-1:0] col_q;
  logic             write_q;

  burst_len_decode #(.CNT_W(CNT_W)) u_decode (
    .code_i (burst_len_i),
    .mask_o (mask)
  );

  burst_beat_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cmd_valid_i),
    .beats_m1_i (mask),
    .active_o   (active),
    .last_o     (last)
  );

  burst_col_stepper #(.COL_W(COL_W), .CNT_W(CNT_W)) u_col (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cmd_valid_i),
    .step_i  (active),
    .col_i   (cmd_col_i),
    .write_i (cmd_write_i),
    .mask_i  (mask),
    .col_o   (col_q),
    .write_o (write_q)
  );

  assign beat_valid_o = active;
  assign busy_o       = active;
  assign beat_last_o  = last;
  assign beat_col_o   = col_q;
  assign beat_write_o = write_q;
endmodule

// File: rtl/sdram_burst_addr_gen_chk.sv
module sdram_burst_addr_gen_chk #(
  parameter int unsigned COL_W = 9,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_write_i,
  input logic [COL_W-1:0] cmd_col_i,
  input logic             beat_valid_o,
  input logic [COL_W-1:0] beat_col_o,
  input logic             beat_write_o,
  input logic             beat_last_o,
  input logic             busy_o
);
  assert_first_col_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> beat_valid_o && beat_col_o == $past(cmd_col_i));

  assert_dir_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> beat_write_o == $past(cmd_write_i));

  assert_dir_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i && beat_valid_o && !beat_last_o) |=> beat_valid_o && $stable(beat_write_o));

  assert_block_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i && beat_valid_o && !beat_last_o) |=>
      beat_col_o[COL_W-1:CNT_W] == $past(beat_col_o[COL_W-1:CNT_W]) &&
      beat_col_o != $past(beat_col_o));

  assert_burst_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i && beat_last_o) |=> !beat_valid_o);

  assert_last_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_last_o |-> busy_o);

  assert_idle_no_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_valid_o |-> !beat_last_o);
endmodule

bind sdram_burst_addr_gen sdram_burst_addr_gen_chk #(
  .COL_W (COL_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_write_i  (cmd_write_i),
  .cmd_col_i    (cmd_col_i),
  .beat_valid_o (beat_valid_o),
  .beat_col_o   (beat_col_o),
  .beat_write_o (beat_write_o),
  .beat_last_o  (beat_last_o),
  .busy_o       (busy_o)
);

// File: tb/tb_sdram_burst_addr_gen.sv
module tb_sdram_burst_addr_gen;
  localparam int unsigned COL_W = 9;
  localparam int unsigned MAX_BL = 8;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       mode = 3'b000;
  logic             cmd = 1'b0;
  logic             wr = 1'b0;
  logic [COL_W-1:0] col = '0;
  logic             valid_o, write_o, last_o, busy_o;
  logic [COL_W-1:0] col_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  bit               m_act = 0;
  int               m_bl = 1;
  int               m_idx = 0;
  logic [COL_W-1:0] m_start = '0;
  logic             m_wr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_addr_gen #(.COL_W(COL_W), .MAX_BL(MAX_BL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .burst_len_i(mode), .cmd_valid_i(cmd),
    .cmd_write_i(wr), .cmd_col_i(col), .beat_valid_o(valid_o), .beat_col_o(col_o),
    .beat_write_o(write_o), .beat_last_o(last_o), .busy_o(busy_o)
  );

  function automatic int len_of(input logic [2:0] c);
    return (c <= 3'd3) ? (1 << c) : 1;
  endfunction

  function automatic logic [COL_W-1:0] exp_col();
    int base, off;
    base = int'(m_start) - (int'(m_start) % m_bl);
    off  = ((int'(m_start) % m_bl) + m_idx) % m_bl;
    return COL_W'(base + off);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_idx = 0;
    end else if (cmd) begin
      m_act = 1; m_bl = len_of(mode); m_idx = 0; m_start = col; m_wr = wr;
    end else if (m_act) begin
      if (m_idx == m_bl - 1) m_act = 0;
      else m_idx++;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 beat_valid_o", valid_o, m_act);
      check("R7 busy_o", busy_o, m_act);
      check("R6 beat_last_o", last_o, m_act && m_idx == m_bl - 1);
      if (m_act) begin
        check("R4 beat_col_o", col_o, exp_col());
        check("R8 beat_write_o", write_o, m_wr);
      end
    end
  end

  task automatic issue(input logic [2:0] m, input logic [COL_W-1:0] c, input logic w);
    mode = m; col = c; wr = w; cmd = 1'b1;
    @(negedge clk);
    cmd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", {valid_o, last_o, busy_o, write_o, col_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: first beat carries the start column
    issue(3'b011, 9'h0A5, 1'b0);
    check("R3 first col", col_o, 9'h0A5);
    repeat (9) @(negedge clk);
    issue(3'b010, 9'h013, 1'b1);
    repeat (5) @(negedge clk);
    issue(3'b001, 9'h1FF, 1'b0);
    repeat (3) @(negedge clk);
    issue(3'b000, 9'h022, 1'b1);
    repeat (2) @(negedge clk);

    // R5: interrupt a running 8-beat read with a 2-beat write
    issue(3'b011, 9'h040, 1'b0);
    repeat (2) @(negedge clk);
    issue(3'b001, 9'h07F, 1'b1);
    check("R5 restart col", col_o, 9'h07F);
    check("R8 interrupt dir", write_o, 1'b1);
    check("R7 busy across interrupt", busy_o, 1'b1);
    @(negedge clk);
    check("R5 second beat", col_o, 9'h07E);
    @(negedge clk);
    check("R5 old beats dropped", valid_o, 1'b0);

    // back-to-back commands on every cycle
    for (int i = 0; i < 6; i++) issue(3'(i % 4), COL_W'(i * 37 + 3), 1'(i));
    repeat (9) @(negedge clk);

    // R9: reserved codes give one beat
    issue(3'b110, 9'h155, 1'b1);
    check("R9 reserved first beat", valid_o, 1'b1);
    @(negedge clk);
    check("R9 reserved single beat", valid_o, 1'b0);
    issue(3'b100, 9'h0C3, 1'b0);
    repeat (2) @(negedge clk);

    // R10: mode change mid-burst is ignored
    issue(3'b010, 9'h0B6, 1'b0);
    mode = 3'b000;
    repeat (3) @(negedge clk);
    check("R10 fourth beat valid", valid_o, 1'b1);
    check("R10 fourth beat col", col_o, 9'h0B5);
    @(negedge clk);
    check("R10 burst ended", valid_o, 1'b0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      cmd  = ($urandom_range(3) == 0);
      mode = 3'($urandom_range(7));
      col  = COL_W'($urandom);
      wr   = 1'($urandom_range(1));
      @(negedge clk);
    end
    cmd = 1'b0;
    repeat (10) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule